// File: doc/BRIEF.md
# Write Stream Drain Gate

This block sits on the word stream that leaves the read side of a write FIFO and enters the write port of a memory access sequencer. All of its logic runs in one clock domain. Between write accesses, software or a sequencer can ask it to discard the stream, so that the FIFO keeps draining rather than filling up while no write is in progress. While it discards, it accepts every word from upstream and passes nothing downstream.

A drain request is honoured only while the sequencer reports that no access is in progress. Once draining, a read access start closes the drain at once. A write access start instead arms the gate. The gate then reopens at a resume point fixed by a parameter: the next valid word, the next start-of-packet word, or the next sync word. Parameters can also require that this resume word carries a channel number inside a configured window. In sync mode the FIFO carries the sync marker in its start-of-packet bit, and the gate moves it back to a separate sync output. The current control state is exported on two bits for monitoring.

Top module: `wr_drain_gate`

## Requirements
- R1: After reset the state output reads 00 and the gate is open. Stream words pass straight through and upstream ready equals downstream ready.
- R2: A drain request moves the state from 00 to 01 on the next clock, but only when done is high. A request made while done is low, or in any state other than 00, has no effect.
- R3: While the gate is closed, upstream ready is 1 and the downstream valid, sop, eop and sync are all 0. The drain-active output is 1 during this time.
- R4: While the gate is open, downstream valid, eop, data and channel equal their inputs in the same cycle, and upstream ready equals downstream ready.
- R5: In state 01, an access enable with write select high moves the state to 10 on the next clock. The gate stays closed until the resume word arrives.
- R6: In state 01 or 10, an access enable with write select low returns the state to 00 on the next clock.
- R7: In valid-resume mode (mode 0), the first valid word seen in state 10 passes downstream in that same cycle, and the state returns to 00.
- R8: In sop-resume mode (mode 1), words in state 10 without the sop bit are dropped. The first valid word with sop set passes in that cycle and ends the drain.
- R9: In sync-resume mode (mode 2), the input sop bit is the sync marker. It appears on the sync output, the sop output is always 0, and the first valid sync word in state 10 resumes the stream.
- R10: With the channel window enabled, a resume word counts only if its channel lies in the range from the first channel up to, but not including, first plus count. A marked word outside this range is dropped.
- R11: The state output uses only the codes 00 (idle), 01 (draining) and 10 (armed for resume).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| accEn | input | 1 | Access start pulse |
| accWrite | input | 1 | 1 = write access, 0 = read access |
| flushReq | input | 1 | Drain request pulse |
| accDone | input | 1 | High while no access is in progress |
| inData | input | DATA_W | Stream data from FIFO |
| inValid | input | 1 | Stream valid from FIFO |
| inSop | input | 1 | Sop bit from FIFO (sync marker in mode 2) |
| inEop | input | 1 | End of packet from FIFO |
| inChan | input | CHAN_W | Channel number from FIFO |
| inReady | output | 1 | Ready to FIFO, zero latency |
| outData | output | DATA_W | Stream data to sequencer |
| outValid | output | 1 | Stream valid to sequencer |
| outSop | output | 1 | Start of packet to sequencer |
| outEop | output | 1 | End of packet to sequencer |
| outSync | output | 1 | Sync marker to sequencer |
| outChan | output | CHAN_W | Channel to sequencer |
| outReady | input | 1 | Ready from sequencer |
| flushActive | output | 1 | 1 while the gate discards words |
| stateVec | output | 2 | Control state code |

## Verification
On every cycle, the assertions check the state transitions: requests are ignored when not idle or not done, read starts cancel, write starts arm, and a resume hit returns to idle. They also check that only legal state codes appear, that a closed gate holds valid low with ready high, and that in sync mode the sop output is never driven. Two things show up only in the bench scenarios. The first is which exact word reopens the stream in each mode, including same-cycle passing of the marker word and rejection of markers on channels outside the window. The second is that a request arriving mid-access really leaves the stream untouched.

// File: rtl/drain_pkg.sv
package drain_pkg;

  localparam int RESUME_ON_VALID = 0;
  localparam int RESUME_ON_SOP   = 1;
  localparam int RESUME_ON_SYNC  = 2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_DRAIN = 2'b01,
    ST_ARMED = 2'b10
  } drainState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic dropAll;   // unconditional discard
    logic armed;     // discard until resume word
  } gateCmd_t;

endpackage

// File: rtl/drain_ctrl.sv
module drain_ctrl
  import drain_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       accEn,
  input  logic       accWrite,
  input  logic       flushReq,
  input  logic       accDone,
  input  logic       markerHit,
  output gateCmd_t   cmd,
  output logic [1:0] stateVec
);

  drainState_t state, stateNxt;

  logic readStart, writeStart;
  assign readStart  = accEn & ~accWrite;
  assign writeStart = accEn & accWrite;

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_IDLE:  if (flushReq && accDone) stateNxt = ST_DRAIN;
      ST_DRAIN: begin
        if (readStart)       stateNxt = ST_IDLE;
        else if (writeStart) stateNxt = ST_ARMED;
      end
      ST_ARMED: begin
        if (readStart || markerHit) stateNxt = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNxt;
  end

  assign cmd.dropAll = (state == ST_DRAIN);
  assign cmd.armed   = (state == ST_ARMED);
  assign stateVec    = state;

  assert_req_ignored_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !(flushReq && accDone)) |=> (state == ST_IDLE));

  assert_req_taken_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && flushReq && accDone) |=> (state == ST_DRAIN));

  assert_write_arms_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DRAIN && accEn && accWrite) |=> (state == ST_ARMED));

  assert_read_cancels_R6: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE && accEn && !accWrite) |=> (state == ST_IDLE));

  assert_hit_releases_R7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ARMED && markerHit) |=> (state == ST_IDLE));

  assert_legal_code_R11: assert property (@(posedge clk) disable iff (rst)
    stateVec != 2'b11);

endmodule

// File: rtl/drain_path.sv
module drain_path
  import drain_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int CHAN_W      = 4,
  parameter int RESUME_MODE = RESUME_ON_VALID,
  parameter bit USE_CHAN    = 1'b0,
  parameter int CHAN_FIRST  = 0,
  parameter int CHAN_COUNT  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  gateCmd_t          cmd,
  input  logic [DATA_W-1:0] inData,
  input  logic              inValid,
  input  logic              inSop,
  input  logic              inEop,
  input  logic [CHAN_W-1:0] inChan,
  output logic              inReady,
  output logic [DATA_W-1:0] outData,
  output logic              outValid,
  output logic              outSop,
  output logic              outEop,
  output logic              outSync,
  output logic [CHAN_W-1:0] outChan,
  input  logic              outReady,
  output logic              markerHit,
  output logic              gateClosed
);

  localparam int EXT_W = CHAN_W + 1;
  localparam logic [EXT_W-1:0] CHAN_LO = EXT_W'(CHAN_FIRST);
  localparam logic [EXT_W-1:0] CHAN_HI = EXT_W'(CHAN_FIRST + CHAN_COUNT);

  logic sopField, syncField, marker, chanOk;

  // restore sync from the sop field when the FIFO carries it there
  generate
    if (RESUME_MODE == RESUME_ON_SYNC) begin : g_syncRemap
      assign sopField  = 1'b0;
      assign syncField = inSop;
      assign marker    = inSop;
    end else if (RESUME_MODE == RESUME_ON_SOP) begin : g_sopMark
      assign sopField  = inSop;
      assign syncField = 1'b0;
      assign marker    = inSop;
    end else begin : g_validMark
      assign sopField  = inSop;
      assign syncField = 1'b0;
      assign marker    = 1'b1;
    end
  endgenerate

  generate
    if (USE_CHAN) begin : g_chanWin
      logic [EXT_W-1:0] chanExt;
      assign chanExt = {1'b0, inChan};
      assign chanOk  = (chanExt >= CHAN_LO) && (chanExt < CHAN_HI);
    end else begin : g_chanAny
      assign chanOk = 1'b1;
    end
  endgenerate

  assign markerHit  = cmd.armed & inValid & marker & chanOk;
  assign gateClosed = cmd.dropAll | (cmd.armed & ~markerHit);

  assign inReady  = gateClosed | outReady;
  assign outData  = inData;
  assign outChan  = inChan;
  assign outValid = inValid   & ~gateClosed;
  assign outSop   = sopField  & ~gateClosed;
  assign outEop   = inEop     & ~gateClosed;
  assign outSync  = syncField & ~gateClosed;

  assert_closed_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    cmd.dropAll |-> (inReady && !outValid && !outSop && !outEop && !outSync));

  assert_open_follow_R4: assert property (@(posedge clk) disable iff (rst)
    (!cmd.dropAll && !cmd.armed) |-> (inReady == outReady && outValid == inValid));

  assert_never_both_R11: assert property (@(posedge clk) disable iff (rst)
    !(cmd.dropAll && cmd.armed));

  generate
    if (RESUME_MODE == RESUME_ON_SYNC) begin : g_syncChk
      assert_sop_cleared_R9: assert property (@(posedge clk) disable iff (rst)
        !outSop);
    end
  endgenerate

endmodule

// File: rtl/wr_drain_gate.sv
module wr_drain_gate
  import drain_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int CHAN_W      = 4,
  parameter int RESUME_MODE = RESUME_ON_VALID,
  parameter bit USE_CHAN    = 1'b0,
  parameter int CHAN_FIRST  = 0,
  parameter int CHAN_COUNT  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accEn,
  input  logic              accWrite,
  input  logic              flushReq,
  input  logic              accDone,
  input  logic [DATA_W-1:0] inData,
  input  logic              inValid,
  input  logic              inSop,
  input  logic              inEop,
  input  logic [CHAN_W-1:0] inChan,
  output logic              inReady,
  output logic [DATA_W-1:0] outData,
  output logic              outValid,
  output logic              outSop,
  output logic              outEop,
  output logic              outSync,
  output logic [CHAN_W-1:0] outChan,
  input  logic              outReady,
  output logic              flushActive,
  output logic [1:0]        stateVec
);

  gateCmd_t cmd;
  logic     markerHit;

  drain_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .accEn     (accEn),
    .accWrite  (accWrite),
    .flushReq  (flushReq),
    .accDone   (accDone),
    .markerHit (markerHit),
    .cmd       (cmd),
    .stateVec  (stateVec)
  );

  drain_path #(
    .DATA_W      (DATA_W),
    .CHAN_W      (CHAN_W),
    .RESUME_MODE (RESUME_MODE),
    .USE_CHAN    (USE_CHAN),
    .CHAN_FIRST  (CHAN_FIRST),
    .CHAN_COUNT  (CHAN_COUNT)
  ) u_path (
    .clk        (clk),
    .rst        (rst),
    .cmd        (cmd),
    .inData     (inData),
    .inValid    (inValid),
    .inSop      (inSop),
    .inEop      (inEop),
    .inChan     (inChan),
    .inReady    (inReady),
    .outData    (outData),
    .outValid   (outValid),
    .outSop     (outSop),
    .outEop     (outEop),
    .outSync    (outSync),
    .outChan    (outChan),
    .outReady   (outReady),
    .markerHit  (markerHit),
    .gateClosed (flushActive)
  );

endmodule

// File: tb/tb_wr_drain_gate.sv
`timescale 1ns/1ps
module tb_wr_drain_gate;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic accEn = 0, accWrite = 0, flushReq = 0, accDone = 1;
  logic [31:0] inData = '0;
  logic inValid = 0, inSop = 0, inEop = 0, outReady = 1;
  logic [3:0] inChan = '0;

  // index 0: valid mode, 1: sop mode with channel window [2,4), 2: sync mode
  logic [2:0]  iReady, oValid, oSop, oEop, oSync, fAct;
  logic [31:0] oData [3];
  logic [3:0]  oChan [3];
  logic [1:0]  stV   [3];

  wr_drain_gate #(.RESUME_MODE(0)) dutVal (
    .clk(clk), .rst(rst), .accEn(accEn), .accWrite(accWrite), .flushReq(flushReq),
    .accDone(accDone), .inData(inData), .inValid(inValid), .inSop(inSop), .inEop(inEop),
    .inChan(inChan), .inReady(iReady[0]), .outData(oData[0]), .outValid(oValid[0]),
    .outSop(oSop[0]), .outEop(oEop[0]), .outSync(oSync[0]), .outChan(oChan[0]),
    .outReady(outReady), .flushActive(fAct[0]), .stateVec(stV[0]));

  wr_drain_gate #(.RESUME_MODE(1), .USE_CHAN(1'b1), .CHAN_FIRST(2), .CHAN_COUNT(2)) dut (
    .clk(clk), .rst(rst), .accEn(accEn), .accWrite(accWrite), .flushReq(flushReq),
    .accDone(accDone), .inData(inData), .inValid(inValid), .inSop(inSop), .inEop(inEop),
    .inChan(inChan), .inReady(iReady[1]), .outData(oData[1]), .outValid(oValid[1]),
    .outSop(oSop[1]), .outEop(oEop[1]), .outSync(oSync[1]), .outChan(oChan[1]),
    .outReady(outReady), .flushActive(fAct[1]), .stateVec(stV[1]));

  wr_drain_gate #(.RESUME_MODE(2)) dutSyn (
    .clk(clk), .rst(rst), .accEn(accEn), .accWrite(accWrite), .flushReq(flushReq),
    .accDone(accDone), .inData(inData), .inValid(inValid), .inSop(inSop), .inEop(inEop),
    .inChan(inChan), .inReady(iReady[2]), .outData(oData[2]), .outValid(oValid[2]),
    .outSop(oSop[2]), .outEop(oEop[2]), .outSync(oSync[2]), .outChan(oChan[2]),
    .outReady(outReady), .flushActive(fAct[2]), .stateVec(stV[2]));

  int nRun = 0, nFail = 0;
  int mState [3] = '{0, 0, 0};
  int mMode  [3] = '{0, 1, 2};
  bit mWin   [3] = '{0, 1, 0};
  bit finished = 0;

  function automatic bit hitOf(int k);
    bit mark, chOk;
    mark = (mMode[k] == 0) ? 1'b1 : inSop;
    chOk = !mWin[k] || (inChan >= 2 && inChan < 4);
    return (mState[k] == 2) && inValid && mark && chOk;
  endfunction

  task automatic step(input logic en, input logic wr, input logic fr, input logic dn,
                      input logic v, input logic s, input logic e, input logic [3:0] ch,
                      input logic rdy, input string tag);
    accEn = en; accWrite = wr; flushReq = fr; accDone = dn;
    inValid = v; inSop = s; inEop = e; inChan = ch; outReady = rdy;
    inData = inData + 32'h1111;
    #1;
    for (int k = 0; k < 3; k++) begin
      bit closed;
      logic [8:0] act, exp;
      closed = (mState[k] == 1) || (mState[k] == 2 && !hitOf(k));
      exp = {closed | rdy, v & ~closed, (mMode[k] == 2) ? 1'b0 : (s & ~closed),
             e & ~closed, (mMode[k] == 2) ? (s & ~closed) : 1'b0, closed,
             2'(mState[k]), 1'b1};
      act = {iReady[k], oValid[k], oSop[k], oEop[k], oSync[k], fAct[k], stV[k],
             (oData[k] == inData) && (oChan[k] == ch)};
      nRun++;
      if (act !== exp) begin
        nFail++;
        $display("FAIL %s dut%0d rdy/val/sop/eop/sync/flush/state/pass act=%b exp=%b",
                 tag, k, act, exp);
      end
    end
    @(posedge clk);
    for (int k = 0; k < 3; k++) begin
      bit hit;
      hit = hitOf(k);
      case (mState[k])
        0: if (fr && dn) mState[k] = 1;
        1: if (en && !wr) mState[k] = 0; else if (en && wr) mState[k] = 2;
        2: if ((en && !wr) || hit) mState[k] = 0;
        default: mState[k] = 0;
      endcase
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state and pass-through
    step(0,0,0,1, 1,1,1,4'd0, 1, "R1");
    step(0,0,0,1, 1,0,0,4'd1, 0, "R4");
    // R2 request while busy is ignored
    step(0,0,1,0, 1,0,0,4'd0, 1, "R2");
    step(0,0,0,0, 1,1,0,4'd0, 1, "R2");
    // R2 request while done is taken
    step(0,0,1,1, 0,0,0,4'd0, 1, "R2");
    // R3 draining, downstream not ready
    step(0,0,1,1, 1,1,1,4'd3, 0, "R3");
    step(0,0,0,1, 1,0,0,4'd2, 0, "R3");
    // R5 write start arms
    step(1,1,0,1, 1,1,0,4'd2, 1, "R5");
    // R7 valid word: dutVal resumes, others drop
    step(0,0,0,0, 1,0,0,4'd2, 1, "R7");
    // R10 sop on channel 0: sop dut keeps dropping; R9 sync dut resumes
    step(0,0,0,0, 1,1,0,4'd0, 1, "R10");
    step(0,0,0,0, 1,1,0,4'd4, 1, "R10");
    step(0,0,0,0, 0,1,0,4'd3, 1, "R8");
    // R8 sop in window resumes
    step(0,0,0,0, 1,1,1,4'd3, 1, "R8");
    step(0,0,0,0, 1,1,0,4'd1, 1, "R9");
    // R6 read start while draining
    step(0,0,1,1, 0,0,0,4'd0, 1, "R6");
    step(1,0,0,1, 1,0,0,4'd0, 1, "R6");
    step(0,0,0,0, 1,1,0,4'd2, 1, "R6");
    // R6 read start while armed
    step(0,0,1,1, 0,0,0,4'd0, 1, "R6");
    step(1,1,0,1, 0,0,0,4'd0, 1, "R11");
    step(0,0,0,0, 0,1,0,4'd2, 1, "R11");
    step(1,0,0,0, 0,0,0,4'd0, 1, "R6");
    step(0,0,0,1, 1,0,1,4'd5, 0, "R4");
    // R9 sync carried in sop field when open
    step(0,0,0,1, 1,1,0,4'd7, 1, "R9");
    step(0,0,1,0, 0,0,0,4'd0, 1, "R2");
    step(0,0,0,1, 1,1,1,4'd0, 1, "R1");
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    #20000;
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

endmodule